// File: doc/BRIEF.md
# Eight-Channel Block Transfer Engine

This block moves data elements between a byte-addressed buffer RAM and peripheral data registers for eight independent channels. Each channel holds its own settings: direction, element size, how the buffer address advances, block length, two buffer start addresses, and its block mode. Software sets these through a write-only register port. A channel asks for an element transfer when its selected request line pulses or when software writes its trigger register.

The channels share one datapath. In each cycle a fixed-priority arbiter picks the lowest-numbered channel with a pending request. That channel moves one element in the same cycle: the source is read combinationally and the destination is written at the clock edge. The channel then advances its address and element count. At block end a channel stops or reloads and continues, and it can alternate between its two buffers. It raises a one-cycle interrupt either at block end or at the half-way element.

Top module: `dma_engine`

Channel registers, selected by `cfg_reg_i`: 0 control, 1 start A, 2 start B, 3 count (block length minus one), 4 trigger (any write), 5 request source index. Control bits: 0 enable, 1 direction, 2 byte, 3 fixed address, 4 peripheral-supplied address, 5 auto-repeat, 6 ping-pong, 7 half-block interrupt.

## Requirements
- R1: After reset every channel is disabled (`ch_en_o`=0), `buf_sel_o` and `irq_o` are 0, and neither `ram_we_o` nor `per_we_o` is asserted.
- R2: In each cycle at most one channel moves one element, and the moving channel is the lowest-indexed channel with a pending request, so channel 0 outranks channel 7.
- R3: Control bit 1 sets the direction. With the bit at 0, `per_rdata_i` is written to RAM. With the bit at 1, RAM data is written to the peripheral, with `per_sel_o` equal to the channel number.
- R4: With control bit 3 clear, the buffer address goes up by 2 after each word element and by 1 after each byte element. With bit 3 set, the address stays at the block start.
- R5: With control bit 2 set, one byte is moved per element. A RAM-to-peripheral byte transfer drives the upper 8 bits of `per_wdata_o` to zero.
- R6: With control bit 4 set, the buffer address is taken from the channel's slice of `per_addr_i` instead of from the channel's own address.
- R7: Writing register 4 of an enabled channel requests one element. A pulse on `req_i[k]` requests one element for each enabled channel whose register 5 holds k. Requests made to a disabled channel are ignored.
- R8: In one-shot mode (bit 5 clear), the enable bit clears after count+1 elements. A single full-block interrupt pulse appears in the cycle after the last element.
- R9: In auto-repeat mode (bit 5 set), the channel reloads its start address and element count at block end and stays enabled.
- R10: In ping-pong mode (bit 6 set), successive blocks alternate between start A and start B, beginning with A. `buf_sel_o` shows the buffer that is active next (0 = A).
- R11: With bit 7 set, the interrupt pulses once per block, after floor(count/2)+1 elements, and there is no pulse at block end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_ch_i | input | 3 | Channel addressed by the write |
| cfg_reg_i | input | 3 | Register index within the channel |
| cfg_wdata_i | input | 16 | Register write data |
| req_i | input | 8 | Request source lines, one-cycle pulses |
| per_addr_i | input | 64 | Peripheral-supplied buffer address, 8 bits per channel |
| ram_addr_o | output | 8 | Buffer RAM byte address |
| ram_we_o | output | 1 | Buffer RAM write enable |
| ram_byte_o | output | 1 | Element is one byte (low lane only) |
| ram_wdata_o | output | 16 | Buffer RAM write data |
| ram_rdata_i | input | 16 | Buffer RAM read data, combinational |
| per_sel_o | output | 3 | Peripheral register selected (channel number) |
| per_we_o | output | 1 | Peripheral register write enable |
| per_rd_o | output | 1 | Peripheral register read strobe |
| per_wdata_o | output | 16 | Peripheral write data |
| per_rdata_i | input | 16 | Peripheral read data, combinational |
| irq_o | output | 8 | Per-channel interrupt pulse |
| ch_en_o | output | 8 | Per-channel enable status |
| buf_sel_o | output | 8 | Per-channel active ping-pong buffer |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the arbitration of two channels and a new request. The second pair is a block-end reload and a buffer switch. Two channels that watch the same source line receive one pulse together, and the bench checks from the peripheral write log that the lower channel moves first and the higher one follows in the next cycle. A ping-pong auto-repeat channel is driven by triggers on consecutive cycles, so the block-end reload, the buffer toggle and the next request all meet at one edge. The bench then checks the final RAM contents, the interrupt count and the buffer flag against values it computes itself.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef struct packed {
    logic half;
    logic pong;
    logic rpt;
    logic pind;
    logic fix;
    logic byt;
    logic dir;
    logic en;
  } ctrl_t;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_STA  = 3'd1,
    REG_STB  = 3'd2,
    REG_CNT  = 3'd3,
    REG_TRIG = 3'd4,
    REG_SRC  = 3'd5
  } reg_e;
endpackage

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] gnt_o
);
  logic [NCH:0] taken;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NCH; i++) begin : g_prio
    assign taken[i+1] = taken[i] | req_i[i];
    assign gnt_o[i]   = req_i[i] & ~taken[i];
  end

  // R2
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R2
  gnt_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & ~req_i) == '0) && ((req_i != '0) == (gnt_o != '0)));
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int AW   = 8,
  parameter int CW   = 8,
  parameter int NSRC = 8,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  reg_e            cfg_reg_i,
  input  logic [15:0]     cfg_wdata_i,
  input  logic [NSRC-1:0] src_req_i,
  input  logic            gnt_i,
  input  logic [AW-1:0]   pia_i,
  output logic            req_o,
  output logic [AW-1:0]   addr_o,
  output ctrl_t           mode_o,
  output logic            irq_o,
  output logic            en_o,
  output logic            buf_o
);
  ctrl_t         ctrl_q;
  logic [AW-1:0] sa_q, sb_q, cur_q, step, next_base;
  logic [CW-1:0] max_q, cnt_q;
  logic [SW-1:0] src_q;
  logic          pend_q, buf_q, irq_q, last, half_pt;

  assign last      = (cnt_q == max_q);
  assign half_pt   = (cnt_q == (max_q >> 1));
  assign step      = ctrl_q.byt ? AW'(1) : AW'(2);
  assign next_base = (ctrl_q.pong && !buf_q) ? sb_q : sa_q;

  assign addr_o = ctrl_q.pind ? pia_i : cur_q;
  assign mode_o = ctrl_q;
  assign req_o  = pend_q & ctrl_q.en;
  assign irq_o  = irq_q;
  assign en_o   = ctrl_q.en;
  assign buf_o  = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sa_q   <= '0;
      sb_q   <= '0;
      cur_q  <= '0;
      max_q  <= '0;
      cnt_q  <= '0;
      src_q  <= '0;
      pend_q <= 1'b0;
      buf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (gnt_i) begin
        pend_q <= 1'b0;
        irq_q  <= ctrl_q.half ? half_pt : last;
        if (last) begin
          cnt_q <= '0;
          cur_q <= next_base;
          if (ctrl_q.pong) buf_q <= ~buf_q;
          if (!ctrl_q.rpt) ctrl_q.en <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
          if (!ctrl_q.fix) cur_q <= cur_q + step;
        end
      end
      if (ctrl_q.en && src_req_i[src_q]) pend_q <= 1'b1;
      if (cfg_we_i) begin
        unique case (cfg_reg_i)
          REG_CTRL: begin
            ctrl_q <= ctrl_t'(cfg_wdata_i[7:0]);
            pend_q <= 1'b0;
            if (cfg_wdata_i[0]) begin
              cur_q <= sa_q;
              cnt_q <= '0;
              buf_q <= 1'b0;
            end
          end
          REG_STA:  sa_q  <= cfg_wdata_i[AW-1:0];
          REG_STB:  sb_q  <= cfg_wdata_i[AW-1:0];
          REG_CNT:  max_q <= cfg_wdata_i[CW-1:0];
          REG_TRIG: if (ctrl_q.en) pend_q <= 1'b1;
          REG_SRC:  src_q <= cfg_wdata_i[SW-1:0];
          default: ;
        endcase
      end
    end
  end

  // R8
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i && last && !ctrl_q.rpt && !cfg_we_i) |=> !en_o);
  // R11
  irq_after_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(gnt_i));
  // R10
  buf_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(buf_o) |-> $past(gnt_i || cfg_we_i));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NSRC = 8,
  parameter int AW   = 8,
  parameter int CW   = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CHW-1:0]    cfg_ch_i,
  input  logic [2:0]        cfg_reg_i,
  input  logic [15:0]       cfg_wdata_i,
  input  logic [NSRC-1:0]   req_i,
  input  logic [NCH*AW-1:0] per_addr_i,
  output logic [AW-1:0]     ram_addr_o,
  output logic              ram_we_o,
  output logic              ram_byte_o,
  output logic [15:0]       ram_wdata_o,
  input  logic [15:0]       ram_rdata_i,
  output logic [CHW-1:0]    per_sel_o,
  output logic              per_we_o,
  output logic              per_rd_o,
  output logic [15:0]       per_wdata_o,
  input  logic [15:0]       per_rdata_i,
  output logic [NCH-1:0]    irq_o,
  output logic [NCH-1:0]    ch_en_o,
  output logic [NCH-1:0]    buf_sel_o
);
  logic [NCH-1:0] ch_req, ch_gnt;
  logic [AW-1:0]  ch_addr [NCH];
  ctrl_t          ch_mode [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_channel #(.AW(AW), .CW(CW), .NSRC(NSRC)) i_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i && (cfg_ch_i == CHW'(i))),
      .cfg_reg_i  (reg_e'(cfg_reg_i)),
      .cfg_wdata_i(cfg_wdata_i),
      .src_req_i  (req_i),
      .gnt_i      (ch_gnt[i]),
      .pia_i      (per_addr_i[i*AW +: AW]),
      .req_o      (ch_req[i]),
      .addr_o     (ch_addr[i]),
      .mode_o     (ch_mode[i]),
      .irq_o      (irq_o[i]),
      .en_o       (ch_en_o[i]),
      .buf_o      (buf_sel_o[i])
    );
  end

  dma_arbiter #(.NCH(NCH)) i_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (ch_req),
    .gnt_o (ch_gnt)
  );

  logic  active;
  ctrl_t mode;
  assign active = |ch_gnt;

  always_comb begin
    ram_addr_o = '0;
    per_sel_o  = '0;
    mode       = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_gnt[i]) begin
        ram_addr_o = ch_addr[i];
        per_sel_o  = CHW'(i);
        mode       = ch_mode[i];
      end
    end
  end

  assign ram_byte_o  = mode.byt;
  assign ram_we_o    = active && !mode.dir;
  assign per_rd_o    = active && !mode.dir;
  assign per_we_o    = active && mode.dir;
  assign ram_wdata_o = per_rdata_i;
  assign per_wdata_o = mode.byt ? {8'h00, ram_rdata_i[7:0]} : ram_rdata_i;
endmodule

// File: tb/test_dma_engine.sv
module test_dma_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_ch = '0;
  logic [2:0]  cfg_reg = '0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0]  req = '0;
  logic [63:0] per_addr = '0;
  logic [7:0]  ram_addr;
  logic        ram_we, ram_byte, per_we, per_rd;
  logic [15:0] ram_wdata, ram_rdata, per_wdata, per_rdata;
  logic [2:0]  per_sel;
  logic [7:0]  irq, ch_en, buf_sel;

  logic [7:0]  mem [256];
  logic [7:0]  pcnt = '0;
  logic [2:0]  log_sel [64];
  logic [15:0] log_dat [64];
  int          nlog = 0;
  int          nwr = 0;
  int          irq_cnt [8];
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_engine i_dma_engine (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_reg_i(cfg_reg), .cfg_wdata_i(cfg_wdata),
    .req_i(req), .per_addr_i(per_addr),
    .ram_addr_o(ram_addr), .ram_we_o(ram_we), .ram_byte_o(ram_byte),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .per_sel_o(per_sel), .per_we_o(per_we), .per_rd_o(per_rd),
    .per_wdata_o(per_wdata), .per_rdata_i(per_rdata),
    .irq_o(irq), .ch_en_o(ch_en), .buf_sel_o(buf_sel)
  );

  assign ram_rdata = {mem[ram_addr + 8'd1], mem[ram_addr]};
  assign per_rdata = {1'b0, per_sel, 4'hA, pcnt};

  always @(posedge clk) begin
    if (ram_we) begin
      mem[ram_addr] <= ram_wdata[7:0];
      if (!ram_byte) mem[ram_addr + 8'd1] <= ram_wdata[15:8];
      nwr <= nwr + 1;
    end
    if (per_rd) pcnt <= pcnt + 8'd1;
    if (per_we && nlog < 64) begin
      log_sel[nlog] <= per_sel;
      log_dat[nlog] <= per_wdata;
      nlog <= nlog + 1;
    end
    for (int c = 0; c < 8; c++) if (irq[c]) irq_cnt[c] <= irq_cnt[c] + 1;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int r, input int d);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_reg = 3'(r); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int ch, input int sa, input int sb, input int cnt, input int ctrl);
    wr(ch, 1, sa); wr(ch, 2, sb); wr(ch, 3, cnt); wr(ch, 0, ctrl);
  endtask

  task automatic trig(input int ch, input int n);
    for (int k = 0; k < n; k++) wr(ch, 4, 1);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] word(input int a);
    return {mem[8'(a + 1)], mem[8'(a)]};
  endfunction

  function automatic logic [15:0] pval(input int ch, input int v);
    return {1'b0, 3'(ch), 4'hA, 8'(v)};
  endfunction

  initial begin
    int p0, n0, w0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int c = 0; c < 8; c++) irq_cnt[c] = 0;
    per_addr[6*8 +: 8] = 8'h40;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 en", 16'(ch_en), 16'h0);
    chk("R1 buf", 16'(buf_sel), 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
    chk("R1 we", {14'h0, ram_we, per_we}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R3 R4 R8: ch2 peripheral->RAM, word, increment, one-shot, 4 elements
    p0 = int'(pcnt);
    setup(2, 'h10, 0, 3, 'h01);
    trig(2, 4);
    for (int k = 0; k < 4; k++) chk("R3 R4 word inc", word('h10 + 2*k), pval(2, p0 + k));
    chk("R8 en clear", 16'(ch_en[2]), 16'h0);
    chk("R8 irq once", 16'(irq_cnt[2]), 16'h1);

    // R5 R3 R4: ch5 RAM->peripheral, byte, increment, 3 elements
    for (int k = 0; k < 4; k++) mem['h30 + k] = 8'(8'h50 + k);
    n0 = nlog;
    setup(5, 'h30, 0, 2, 'h07);
    trig(5, 3);
    chk("R5 count", 16'(nlog - n0), 16'd3);
    for (int k = 0; k < 3; k++) begin
      chk("R5 byte zext", log_dat[n0 + k], {8'h00, 8'(8'h50 + k)});
      chk("R3 per_sel", 16'(log_sel[n0 + k]), 16'd5);
    end

    // R4 fixed address: ch1 word, 3 elements all at 0x50
    p0 = int'(pcnt);
    setup(1, 'h50, 0, 2, 'h09);
    trig(1, 3);
    chk("R4 fixed last", word('h50), pval(1, p0 + 2));
    chk("R4 fixed untouched", word('h52), 16'h0000);

    // R2 R7: ch3 and ch6 watch source 4, ch0 watches source 2
    setup(3, 'h00, 0, 3, 'h03); wr(3, 5, 4);
    setup(6, 'h02, 0, 3, 'h03); wr(6, 5, 4);
    setup(0, 'h04, 0, 3, 'h03); wr(0, 5, 2);
    n0 = nlog;
    req = 8'h10;
    @(negedge clk);
    req = 8'h00;
    repeat (4) @(negedge clk);
    chk("R2 R7 two moves", 16'(nlog - n0), 16'd2);
    chk("R2 first ch3", 16'(log_sel[n0]), 16'd3);
    chk("R2 then ch6", 16'(log_sel[n0 + 1]), 16'd6);

    // R9 R10: ch0 ping-pong auto-repeat, 2-element blocks, 6 elements
    p0 = int'(pcnt);
    for (int c = 0; c < 8; c++) irq_cnt[c] = 0;
    setup(0, 'h80, 'hA0, 1, 'h61);
    trig(0, 6);
    chk("R10 A0", word('h80), pval(0, p0 + 4));
    chk("R10 A1", word('h82), pval(0, p0 + 5));
    chk("R10 B0", word('hA0), pval(0, p0 + 2));
    chk("R10 B1", word('hA2), pval(0, p0 + 3));
    chk("R10 buf flag", 16'(buf_sel[0]), 16'h1);
    chk("R9 stays en", 16'(ch_en[0]), 16'h1);
    chk("R9 irq per block", 16'(irq_cnt[0]), 16'd3);
    wr(0, 0, 0);

    // R9 auto-repeat without ping-pong: ch7, 3 elements
    p0 = int'(pcnt);
    setup(7, 'hC0, 'hD0, 1, 'h21);
    trig(7, 3);
    chk("R9 reload", word('hC0), pval(7, p0 + 2));
    chk("R9 second", word('hC2), pval(7, p0 + 1));
    chk("R9 no B", word('hD0), 16'h0000);
    chk("R9 irq", 16'(irq_cnt[7]), 16'd1);
    chk("R10 buf idle", 16'(buf_sel[7]), 16'h0);
    wr(7, 0, 0);

    // R11 half-block interrupt: ch4, 6 elements, one-shot
    setup(4, 'hE0, 0, 5, 'h81);
    trig(4, 2);
    chk("R11 before half", 16'(irq_cnt[4]), 16'd0);
    trig(4, 1);
    chk("R11 at half", 16'(irq_cnt[4]), 16'd1);
    trig(4, 3);
    chk("R11 no full irq", 16'(irq_cnt[4]), 16'd1);
    chk("R8 half one-shot", 16'(ch_en[4]), 16'h0);

    // R6 peripheral-supplied address: ch6 lands at 0x40, not 0x60
    p0 = int'(pcnt);
    setup(6, 'h60, 0, 3, 'h11);
    trig(6, 2);
    chk("R6 pia addr", word('h40), pval(6, p0 + 1));
    chk("R6 own addr unused", word('h60), 16'h0000);

    // R7 disabled channel ignores trigger and source
    w0 = nwr;
    n0 = nlog;
    wr(1, 5, 3);
    trig(1, 2);
    req = 8'h08;
    @(negedge clk);
    req = 8'h00;
    repeat (3) @(negedge clk);
    chk("R7 ignored ram", 16'(nwr - w0), 16'd0);
    chk("R7 ignored per", 16'(nlog - n0), 16'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule